// File: doc/BRIEF.md
# Addressable Bit Latch

This block is a bank of single-bit storage cells, each with its own output pin. Bits are written one at a time: a binary select bus picks the cell and a single data line supplies the value. Two active-low controls, a write enable and a clear, together choose one of four operating modes. In write mode only the selected cell is updated. In hold mode nothing changes. In demultiplex mode the selected output carries the data and all others go low. In clear mode every output goes low.

The block is a synchronous model. All inputs are sampled on the rising edge of the system clock, and each output changes one clock after the mode that causes it is applied. In demultiplex mode the cells that are not selected are really cleared, not just masked. When the controls return to hold, the outputs therefore keep showing the last demultiplex pattern. With the data line tied high, demultiplex mode turns the block into an active-high binary-to-one-hot decoder.

A typical use is turning a serial bit stream into a parallel control word. Another is driving a set of one-hot strobes from a small address.

Top module: `addr_bit_latch`

## Requirements
- R1: A synchronous active-high `rst` drives every output low at the next rising clock edge.
- R2: The control pair selects the mode as follows. `wr_en_n`=0 with `clr_n`=1 is write. `wr_en_n`=1 with `clr_n`=1 is hold. `wr_en_n`=0 with `clr_n`=0 is demultiplex. `wr_en_n`=1 with `clr_n`=0 is clear.
- R3: In write mode, output `q[sel]` takes `din` and every other output keeps its previous value.
- R4: In hold mode, every output keeps its value, whatever `sel` and `din` do, including `sel` changing several bits at once.
- R5: In demultiplex mode, `q[sel]` takes `din` and every other output goes low, so at most one output is high.
- R6: In demultiplex mode with `din`=1, `q` equals `1 << sel` for every select value (one-hot decode).
- R7: In clear mode, all outputs go low whatever `sel` and `din` are. Clear takes priority over the select decode.
- R8: An output changes only at the rising clock edge that samples the mode. Between edges, input changes do not reach `q`.
- R9: After a write, the value a bit keeps once the controls return to hold is the `din` sampled at the last write edge.
- R10: The pattern left by demultiplex mode is stored and stays on `q` through later hold cycles.
- R11: `sel` is binary with bit 0 least significant. The value k selects output `q[k]`, for k from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_n | input | 1 | Write enable, active low |
| clr_n | input | 1 | Clear, active low |
| sel | input | 3 | Binary select of the target bit |
| din | input | 1 | Serial data input |
| q | output | 8 | Stored bit outputs |

## Verification
Two functions can act in the same cycle: the select decode and the clear. Clear mode must win over any address and data present on its edge. Demultiplex mode must load the selected bit and clear the other seven on that single edge. The bench provokes this by filling the bank with a mixed pattern and then applying clear or demultiplex while `sel` and `din` hold values that would otherwise write a bit. A per-cycle reference model then checks all eight outputs together after each edge. It also checks that nothing moved before the edge.

// File: rtl/abl_pkg.sv
package abl_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } abl_mode_e;

    typedef struct packed {
        logic en_n;
        logic clr_n;
    } abl_ctl_t;

    function automatic abl_mode_e abl_mode_of(input abl_ctl_t ctl);
        abl_mode_e m;
        case ({ctl.en_n, ctl.clr_n})
            2'b01:   m = MODE_WRITE;
            2'b11:   m = MODE_HOLD;
            2'b00:   m = MODE_DEMUX;
            default: m = MODE_CLEAR;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/abl_mode_dec.sv
module abl_mode_dec
    import abl_pkg::*;
(
    input  logic      wr_en_n,
    input  logic      clr_n,
    output abl_mode_e mode
);
    abl_ctl_t ctl;

    always_comb begin
        ctl.en_n  = wr_en_n;
        ctl.clr_n = clr_n;
        mode      = abl_mode_of(ctl);
    end
endmodule

// File: rtl/abl_sel_dec.sv
module abl_sel_dec #(
    parameter int NUM_BITS = 8,
    parameter int SEL_W    = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
    input  logic [SEL_W-1:0]    sel,
    output logic [NUM_BITS-1:0] hit
);
    for (genvar i = 0; i < NUM_BITS; i++) begin : g_hit
        assign hit[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/abl_bit_cell.sv
module abl_bit_cell
    import abl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  abl_mode_e mode,
    input  logic      hit,
    input  logic      din,
    output logic      q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            case (mode)
                MODE_WRITE: if (hit) q <= din;
                MODE_HOLD:  q <= q;
                MODE_DEMUX: q <= hit & din;
                default:    q <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
    import abl_pkg::*;
#(
    parameter int NUM_BITS = 8,
    localparam int SEL_W   = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en_n,
    input  logic                clr_n,
    input  logic [SEL_W-1:0]    sel,
    input  logic                din,
    output logic [NUM_BITS-1:0] q
);
    abl_mode_e             mode;
    logic [NUM_BITS-1:0]   hit;

    abl_mode_dec u_mode (
        .wr_en_n (wr_en_n),
        .clr_n   (clr_n),
        .mode    (mode)
    );

    abl_sel_dec #(.NUM_BITS(NUM_BITS), .SEL_W(SEL_W)) u_sel (
        .sel (sel),
        .hit (hit)
    );

    for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
        abl_bit_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .hit  (hit[i]),
            .din  (din),
            .q    (q[i])
        );
    end
endmodule

// File: rtl/abl_chk.sv
module abl_chk #(
    parameter int NUM_BITS = 8,
    localparam int SEL_W   = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en_n,
    input logic                clr_n,
    input logic [SEL_W-1:0]    sel,
    input logic                din,
    input logic [NUM_BITS-1:0] q
);
    logic armed = 1'b0;

    always_ff @(posedge clk) armed <= !rst;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q == '0));

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(wr_en_n) && $past(clr_n)) |-> (q == $past(q)));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(wr_en_n) && !$past(clr_n)) |-> (q == '0));

    // R5
    demux_pat_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(wr_en_n) && !$past(clr_n))
        |-> (q == ($past(din) ? (NUM_BITS'(1) << $past(sel)) : '0)));

    // R5
    demux_onehot_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(wr_en_n) && !$past(clr_n)) |-> $onehot0(q));

    // R3
    write_others_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(wr_en_n) && $past(clr_n))
        |-> (((q ^ $past(q)) & ~(NUM_BITS'(1) << $past(sel))) == '0));

    // R3
    write_bit_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(wr_en_n) && $past(clr_n)) |-> (q[$past(sel)] == $past(din)));
endmodule

bind addr_bit_latch abl_chk #(.NUM_BITS(NUM_BITS)) u_abl_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en_n (wr_en_n),
    .clr_n   (clr_n),
    .sel     (sel),
    .din     (din),
    .q       (q)
);

// File: tb/tb_addr_bit_latch.sv
`timescale 1ns/1ps
module tb_addr_bit_latch;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [2:0] sel = '0;
    logic       din = 1'b0;
    logic [7:0] q;

    logic [7:0] ref_q = '0;
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    addr_bit_latch dut (
        .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .clr_n(clr_n),
        .sel(sel), .din(din), .q(q)
    );

    task automatic check(input string tag, input logic [7:0] exp);
        n_chk++;
        if (q !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%b expected=%b", tag, q, exp);
        end
    endtask

    // Apply one cycle of inputs, advance the model, compare after the edge.
    task automatic step(input logic en_n, input logic c_n, input logic [2:0] s,
                        input logic d, input string tag);
        @(negedge clk);
        wr_en_n = en_n; clr_n = c_n; sel = s; din = d;
        @(posedge clk);
        #1;
        if (rst)                 ref_q = '0;
        else if (!en_n && c_n)   ref_q[s] = d;
        else if (!en_n && !c_n)  ref_q = d ? (8'd1 << s) : 8'd0;
        else if (en_n && !c_n)   ref_q = '0;
        check(tag, ref_q);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: q=%b expected=completion", q);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", 8'h00);
        rst = 1'b0;

        // R3 / R11: walk all eight addresses with a mixed pattern
        for (int k = 0; k < 8; k++)
            step(1'b0, 1'b1, 3'(k), 1'(k % 2 == 0), "R3 R11 write");
        check("R11 write pattern", 8'b0101_0101);

        // R8: inputs between edges do not reach q
        @(negedge clk);
        wr_en_n = 1'b0; clr_n = 1'b1; sel = 3'd7; din = 1'b1;
        #1;
        check("R8 no change before edge", ref_q);
        @(posedge clk); #1;
        ref_q[7] = 1'b1;
        check("R8 update at edge", ref_q);

        // R9: write then hold with data flipping
        step(1'b0, 1'b1, 3'd2, 1'b1, "R9 write");
        step(1'b1, 1'b1, 3'd2, 1'b0, "R9 hold keeps last data");

        // R4: hold ignores random select/data, including multi-bit jumps
        for (int k = 0; k < 40; k++)
            step(1'b1, 1'b1, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 "R4 hold");
        step(1'b1, 1'b1, 3'd0, 1'b1, "R4 hold jump");
        step(1'b1, 1'b1, 3'd7, 1'b0, "R4 hold jump");

        // R7: clear with select/data that would write
        step(1'b1, 1'b0, 3'd5, 1'b1, "R7 clear priority");
        check("R7 all low", 8'h00);

        // R6: decoder over all select values
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 1'b0, 3'(k), 1'b1, "R6 decode");
            check("R6 one-hot", 8'd1 << k);
        end

        // R5 / R10: demux from a full bank, then hold
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 3'(k), 1'b1, "R3 fill");
        step(1'b0, 1'b0, 3'd3, 1'b1, "R5 demux data high");
        check("R5 others cleared", 8'b0000_1000);
        step(1'b1, 1'b1, 3'd6, 1'b1, "R10 hold after demux");
        step(1'b1, 1'b1, 3'd1, 1'b0, "R10 hold after demux");
        step(1'b0, 1'b0, 3'd4, 1'b0, "R5 demux data low");
        check("R5 all low", 8'h00);

        // R2: mode sweep with random inputs
        for (int k = 0; k < 200; k++) begin
            logic [1:0] m = 2'($urandom_range(0, 3));
            step(m[1], m[0], 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 "R2 mode mix");
        end

        // R1: reset mid-run
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 3'(k), 1'b1, "R3 fill");
        rst = 1'b1;
        step(1'b0, 1'b1, 3'd0, 1'b1, "R1 reset mid-run");
        rst = 1'b0;
        step(1'b1, 1'b1, 3'd0, 1'b0, "R1 hold after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule